// File: doc/BRIEF.md
# Register Rename Status Table

This block sits beside a small architectural value file in an out-of-order issue stage. For every architectural register it keeps the tag of the in-flight producer that will write that register, or a blank tag (zero) when nothing is pending. When an instruction issues, the block answers for each of its sources with one of two things. If the register is settled, it gives the current value and a zero tag. If a producer is pending, it gives that producer's tag. In the same cycle it records the issuing instruction's tag as the new pending producer of its destination.

The block also listens to the result broadcast bus. A broadcast carries a tag and a value. Every register whose recorded tag equals the broadcast tag takes the value and returns to the blank state. Because each issue overwrites the destination's tag, a newer writer replaces an older one. The older producer's result is then ignored by the table, so write-after-write and write-after-read conflicts never stall issue. A source whose pending tag matches the broadcast in the same cycle is answered with the broadcast value and a zero tag. Scheduling stations, execution and in-order retirement live elsewhere.

Top module: `rst_table`

## Requirements
- R1: After reset every register reads as value 0 with tag 0.
- R2: A source whose register has tag 0 returns the stored value with tag 0 in the same cycle as its select.
- R3: A source whose register has a non-zero tag, and that is not bypassed by R9, returns that tag with a value field of 0.
- R4: An issue (issue_valid high) sets the tag of register issue_dst to issue_tag, visible from the next cycle.
- R5: A broadcast (bcast_valid high, bcast_tag non-zero) whose tag equals a register's tag writes bcast_value into that register and sets its tag to 0, visible from the next cycle.
- R6: A broadcast with bcast_valid low, with tag 0, or with a tag different from a register's tag leaves that register's value and tag unchanged.
- R7: After a second issue to the same register, a broadcast of the first tag leaves the register pending on the second tag with its value unchanged.
- R8: When an issue to a register and a broadcast matching that register's old tag happen in the same cycle, the register's tag becomes the new issue_tag.
- R9: A source whose register tag is non-zero and equals a valid non-zero bcast_tag in the same cycle returns bcast_value with tag 0.
- R10: Sources are answered from the state before the same cycle's issue, so a source equal to the destination sees the older tag or value.
- R11: One broadcast updates every register that holds its tag.
- R12: Register 0 is an ordinary register that follows R1 to R11 like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | An instruction issues this cycle |
| issue_dst | input | 4 | Destination register of the issuing instruction |
| issue_tag | input | 4 | Tag of the producer the destination will wait on |
| src_sel | input | 8 | Source register selects, port k in bits [4k+3:4k] |
| src_value | output | 128 | Source values, port k in bits [64k+63:64k] |
| src_tag | output | 8 | Source tags, port k in bits [4k+3:4k], 0 means value is valid |
| bcast_valid | input | 1 | A result is on the broadcast bus |
| bcast_tag | input | 4 | Tag of the broadcasting producer |
| bcast_value | input | 64 | Broadcast result value |

## Verification
The lookup is tried with directed patterns first. A pending source is read before its result arrives, which separates R3 from R2. The same source is read in the cycle of its broadcast, which separates the bypass of R9 from a plain pending read. Two issues to one register followed by the older tag's broadcast separate a real overwrite (R7) from a table that still accepts the old producer. An issue and a matching broadcast in the same cycle show which of the two wins (R8). Long runs of seeded random issues, broadcasts and selects use a small pool of tags, so coincident tags, shared tags across registers and stale broadcasts occur often, and each is checked against a bench model built from the requirements.

// File: rtl/rst_pkg.sv
package rst_pkg;
   localparam int unsigned DEF_NUM_REGS = 16;
   localparam int unsigned DEF_DATA_W   = 64;
   localparam int unsigned DEF_TAG_W    = 4;
   localparam int unsigned DEF_NUM_SRC  = 2;

   typedef enum logic [1:0] {
      ANS_STORED  = 2'd0,
      ANS_BYPASS  = 2'd1,
      ANS_PENDING = 2'd2
   } answer_kind_e;
endpackage

// File: rtl/rst_entry.sv
module rst_entry #(
   parameter int unsigned TAG_W  = 4,
   parameter int unsigned DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic              bc_valid,
   input  logic [TAG_W-1:0]  bc_tag,
   input  logic [DATA_W-1:0] bc_value,
   output logic [TAG_W-1:0]  tag_q,
   output logic [DATA_W-1:0] val_q
);
   logic bc_hit;

   assign bc_hit = bc_valid && (bc_tag != '0) && (bc_tag == tag_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_q <= '0;
         val_q <= '0;
      end else begin
         if (bc_hit)
            val_q <= bc_value;
         if (wr_en)
            tag_q <= wr_tag;
         else if (bc_hit)
            tag_q <= '0;
      end
   end

   p_tag_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> tag_q == $past(wr_tag));

   p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_hit && !wr_en) |=> (tag_q == '0) && (val_q == $past(bc_value)));

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!bc_hit && !wr_en) |=> $stable(tag_q) && $stable(val_q));

   p_new_tag_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_hit && wr_en) |=> tag_q == $past(wr_tag));
endmodule

// File: rtl/rst_src_port.sv
module rst_src_port
   import rst_pkg::*;
#(
   parameter int unsigned NUM_REGS  = 16,
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned TAG_W     = 4,
   parameter bit          BYPASS_EN = 1'b1,
   localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [IDX_W-1:0]                 sel,
   input  logic [NUM_REGS-1:0][TAG_W-1:0]   tags,
   input  logic [NUM_REGS-1:0][DATA_W-1:0]  vals,
   input  logic                             bc_valid,
   input  logic [TAG_W-1:0]                 bc_tag,
   input  logic [DATA_W-1:0]                bc_value,
   output logic [DATA_W-1:0]                out_value,
   output logic [TAG_W-1:0]                 out_tag
);
   logic [TAG_W-1:0]  cur_tag;
   logic [DATA_W-1:0] cur_val;
   logic              bypass_hit;
   answer_kind_e      kind;

   assign cur_tag = tags[sel];
   assign cur_val = vals[sel];

   generate
      if (BYPASS_EN) begin : g_bypass
         assign bypass_hit = bc_valid && (bc_tag != '0) && (bc_tag == cur_tag);
      end else begin : g_no_bypass
         assign bypass_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      if (cur_tag == '0)
         kind = ANS_STORED;
      else if (bypass_hit)
         kind = ANS_BYPASS;
      else
         kind = ANS_PENDING;
   end

   always_comb begin
      unique case (kind)
         ANS_STORED:  begin out_value = cur_val;  out_tag = '0;      end
         ANS_BYPASS:  begin out_value = bc_value; out_tag = '0;      end
         default:     begin out_value = '0;       out_tag = cur_tag; end
      endcase
   end

   p_pending_zero_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_tag != '0) |-> (out_value == '0));

   p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (BYPASS_EN && bc_valid && bc_tag != '0 && tags[sel] == bc_tag)
         |-> (out_tag == '0) && (out_value == bc_value));
endmodule

// File: rtl/rst_table.sv
module rst_table
   import rst_pkg::*;
#(
   parameter int unsigned NUM_REGS  = DEF_NUM_REGS,
   parameter int unsigned DATA_W    = DEF_DATA_W,
   parameter int unsigned TAG_W     = DEF_TAG_W,
   parameter int unsigned NUM_SRC   = DEF_NUM_SRC,
   parameter bit          BYPASS_EN = 1'b1,
   localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      issue_valid,
   input  logic [IDX_W-1:0]          issue_dst,
   input  logic [TAG_W-1:0]          issue_tag,
   input  logic [NUM_SRC*IDX_W-1:0]  src_sel,
   output logic [NUM_SRC*DATA_W-1:0] src_value,
   output logic [NUM_SRC*TAG_W-1:0]  src_tag,
   input  logic                      bcast_valid,
   input  logic [TAG_W-1:0]          bcast_tag,
   input  logic [DATA_W-1:0]         bcast_value
);
   initial begin
      assert (NUM_REGS >= 2 && (1 << IDX_W) == NUM_REGS)
         else $error("NUM_REGS must be a power of two of at least 2");
      assert (TAG_W >= 1 && TAG_W <= 16) else $error("TAG_W out of range");
      assert (DATA_W >= 1) else $error("DATA_W must be positive");
      assert (NUM_SRC >= 1 && NUM_SRC <= 8) else $error("NUM_SRC out of range");
   end

   logic [NUM_REGS-1:0][TAG_W-1:0]  tag_arr;
   logic [NUM_REGS-1:0][DATA_W-1:0] val_arr;

   generate
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
         logic hit_dst;
         assign hit_dst = issue_valid && (issue_dst == IDX_W'(r));
         rst_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (hit_dst),
            .wr_tag   (issue_tag),
            .bc_valid (bcast_valid),
            .bc_tag   (bcast_tag),
            .bc_value (bcast_value),
            .tag_q    (tag_arr[r]),
            .val_q    (val_arr[r])
         );
      end

      for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
         rst_src_port #(
            .NUM_REGS  (NUM_REGS),
            .DATA_W    (DATA_W),
            .TAG_W     (TAG_W),
            .BYPASS_EN (BYPASS_EN)
         ) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (src_sel[k*IDX_W +: IDX_W]),
            .tags      (tag_arr),
            .vals      (val_arr),
            .bc_valid  (bcast_valid),
            .bc_tag    (bcast_tag),
            .bc_value  (bcast_value),
            .out_value (src_value[k*DATA_W +: DATA_W]),
            .out_tag   (src_tag[k*TAG_W +: TAG_W])
         );
      end
   endgenerate

   p_issue_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && !(bcast_valid && bcast_tag != '0 && bcast_tag == issue_tag))
         |=> (src_sel[IDX_W-1:0] != $past(issue_dst)) || (src_tag[TAG_W-1:0] == $past(issue_tag))
             || (issue_valid && issue_dst == $past(issue_dst))
             || (bcast_valid && bcast_tag == $past(issue_tag)));

   p_reg0_ordinary_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_dst == '0) |=> tag_arr[0] == $past(issue_tag));
endmodule

// File: tb/rst_table_tb.sv
module rst_table_tb_top;
   localparam int NR = 16;
   localparam int DW = 64;
   localparam int TW = 4;
   localparam int NS = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          issue_valid = 1'b0;
   logic [3:0]    issue_dst = '0;
   logic [3:0]    issue_tag = '0;
   logic [7:0]    src_sel = '0;
   logic [127:0]  src_value;
   logic [7:0]    src_tag;
   logic          bcast_valid = 1'b0;
   logic [3:0]    bcast_tag = '0;
   logic [63:0]   bcast_value = '0;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [TW-1:0] m_tag [NR];
   logic [DW-1:0] m_val [NR];

   always #2.5 clk = ~clk;

   rst_table dut_i (
      .clk(clk), .rst_n(rst_n),
      .issue_valid(issue_valid), .issue_dst(issue_dst), .issue_tag(issue_tag),
      .src_sel(src_sel), .src_value(src_value), .src_tag(src_tag),
      .bcast_valid(bcast_valid), .bcast_tag(bcast_tag), .bcast_value(bcast_value)
   );

   function automatic logic [DW+TW-1:0] expect_src(input logic [3:0] s);
      if (m_tag[s] == '0)
         return {m_val[s], 4'h0};
      if (bcast_valid && bcast_tag != '0 && bcast_tag == m_tag[s])
         return {bcast_value, 4'h0};
      return {64'h0, m_tag[s]};
   endfunction

   task automatic model_update();
      for (int r = 0; r < NR; r++) begin
         if (bcast_valid && bcast_tag != '0 && m_tag[r] == bcast_tag) begin
            m_val[r] = bcast_value;
            m_tag[r] = '0;
         end
         if (issue_valid && issue_dst == 4'(r))
            m_tag[r] = issue_tag;
      end
   endtask

   task automatic check_ports(input string req);
      for (int k = 0; k < NS; k++) begin
         logic [DW+TW-1:0] exp_v;
         logic [DW+TW-1:0] act_v;
         exp_v = expect_src(src_sel[k*4 +: 4]);
         act_v = {src_value[k*DW +: DW], src_tag[k*TW +: TW]};
         checks++;
         if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s port %0d reg %0d: actual value=%h tag=%h expected value=%h tag=%h",
                     req, k, src_sel[k*4 +: 4], act_v[DW+TW-1:TW], act_v[TW-1:0],
                     exp_v[DW+TW-1:TW], exp_v[TW-1:0]);
         end
      end
   endtask

   // called at a negedge: drive, check, clock, update model, return at next negedge
   task automatic step(input bit iv, input logic [3:0] dst, input logic [3:0] itag,
                       input bit bv, input logic [3:0] bt, input logic [63:0] bval,
                       input logic [3:0] s0, input logic [3:0] s1, input string req);
      issue_valid = iv; issue_dst = dst; issue_tag = itag;
      bcast_valid = bv; bcast_tag = bt; bcast_value = bval;
      src_sel = {s1, s0};
      #1;
      check_ports(req);
      @(posedge clk);
      model_update();
      @(negedge clk);
   endtask

   task automatic look(input logic [3:0] s0, input logic [3:0] s1, input string req);
      step(1'b0, 4'h0, 4'h0, 1'b0, 4'h0, 64'h0, s0, s1, req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      for (int r = 0; r < NR; r++) begin m_tag[r] = '0; m_val[r] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      look(4'd0, 4'd15, "R1");
      look(4'd7, 4'd8,  "R1");

      // R12/R4/R3: register 0 goes pending
      step(1'b1, 4'd0, 4'd5, 1'b0, 4'd0, 64'h0, 4'd0, 4'd1, "R12 R4");
      look(4'd0, 4'd0, "R3 R4 R12");
      // R9: bypass in the broadcast cycle
      step(1'b0, 4'd0, 4'd0, 1'b1, 4'd5, 64'hDEAD_BEEF_0123_4567, 4'd0, 4'd0, "R9");
      // R5/R2: value captured and tag cleared
      look(4'd0, 4'd1, "R5 R2 R12");

      // R11: one broadcast, two registers
      step(1'b1, 4'd1, 4'd6, 1'b0, 4'd0, 64'h0, 4'd1, 4'd2, "R11");
      step(1'b1, 4'd2, 4'd6, 1'b0, 4'd0, 64'h0, 4'd1, 4'd2, "R11");
      step(1'b0, 4'd0, 4'd0, 1'b1, 4'd6, 64'h1111_2222_3333_4444, 4'd3, 4'd4, "R11");
      look(4'd1, 4'd2, "R11");

      // R6: non-matching, zero-tag and invalid broadcasts
      step(1'b1, 4'd3, 4'd7, 1'b0, 4'd0, 64'h0, 4'd3, 4'd0, "R6");
      step(1'b0, 4'd0, 4'd0, 1'b1, 4'd8, 64'hAAAA_0000_0000_0001, 4'd3, 4'd0, "R6");
      step(1'b0, 4'd0, 4'd0, 1'b1, 4'd0, 64'hAAAA_0000_0000_0002, 4'd3, 4'd0, "R6");
      step(1'b0, 4'd0, 4'd0, 1'b0, 4'd7, 64'hAAAA_0000_0000_0003, 4'd3, 4'd4, "R6");
      look(4'd3, 4'd0, "R6");

      // R7: older producer superseded
      step(1'b1, 4'd4, 4'd9,  1'b0, 4'd0, 64'h0, 4'd4, 4'd4, "R7");
      step(1'b1, 4'd4, 4'd10, 1'b0, 4'd0, 64'h0, 4'd4, 4'd4, "R7");
      step(1'b0, 4'd0, 4'd0, 1'b1, 4'd9, 64'h9999_9999_9999_9999, 4'd4, 4'd0, "R7");
      look(4'd4, 4'd4, "R7");
      step(1'b0, 4'd0, 4'd0, 1'b1, 4'd10, 64'h1010_1010_1010_1010, 4'd5, 4'd0, "R7");
      look(4'd4, 4'd0, "R7");

      // R8: issue and matching broadcast collide
      step(1'b1, 4'd5, 4'd11, 1'b0, 4'd0, 64'h0, 4'd5, 4'd0, "R8");
      step(1'b1, 4'd5, 4'd12, 1'b1, 4'd11, 64'h5555_6666_7777_8888, 4'd5, 4'd0, "R8");
      look(4'd5, 4'd5, "R8");

      // R10: source equal to destination sees older state
      step(1'b1, 4'd4, 4'd13, 1'b0, 4'd0, 64'h0, 4'd4, 4'd4, "R10");
      look(4'd4, 4'd1, "R10");

      // random mix: R2 R3 R5 R9 R11 under coincident tags
      for (int i = 0; i < 3000; i++) begin
         logic [3:0] d;
         d = 4'($urandom_range(0, 15));
         if ($urandom_range(0, 1) == 0) d = d & 4'h3;
         step(($urandom_range(0, 2) == 0), d, 4'($urandom_range(1, 3)),
              ($urandom_range(0, 1) == 0), 4'($urandom_range(0, 3)),
              {$urandom, $urandom},
              4'($urandom_range(0, 15)), 4'($urandom_range(0, 7)),
              "R2 R3 R5 R9 random");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule